// File: doc/BRIEF.md
# Three-Channel Window Overlay Selector

This block sits next to a display timing generator and, on every pixel clock, decides which of three layered input channels owns the current raster position. Each channel has a rectangular window given by two corner registers, an enable bit and a packed background colour. The block picks the highest-priority enabled channel whose window covers the position. It then outputs that channel's index, its pixel (or its background colour when the pixel is not valid), and the alpha value that goes with it. When no channel covers the position, the first channel's background colour is output.

Configuration arrives through a simple indexed register write port. The pixel data for each channel comes from upstream fetch logic. Only the first channel may carry a per-pixel alpha, and a control bit chooses between that per-pixel alpha and a register default. A 3-bit swap code reorders the three colour components on the way out. All outputs are registered, so each decision appears one clock after its position is presented.

Top module: `ovl_win_select`

## Requirements
- R1: Outputs are registered. The values present at `pos_x`, `pos_y`, the pixel inputs and the configuration before a rising edge appear on the outputs after that edge. A register write in that same cycle affects only later positions.
- R2: A window covers a position when corner1.x <= x <= corner2.x and corner1.y <= y <= corner2.y, with both bounds inclusive. A corner word holds X in bits 12:0 and Y in bits 28:16.
- R3: A channel whose two corner registers are both zero never covers any position, whatever its enable bit is.
- R4: The control register enables channel 1 with bit 2, channel 2 with bit 1 and channel 3 with bit 0. A disabled channel never wins.
- R5: Priority is fixed: channel 1 over channel 2 over channel 3. `out_sel` is 1, 2 or 3 for the winning channel, and 0 when no channel covers the position.
- R6: When no channel covers the position, `out_sel` is 0 and `out_pix` carries channel 1's background colour.
- R7: When the winning channel's valid bit is low, its own background colour replaces its pixel, and `out_sel` still names that channel. In `ch_vld`, bit 0 belongs to channel 1, bit 1 to channel 2 and bit 2 to channel 3.
- R8: Colours pack three 10-bit components: the first in bits 29:20, the second in bits 19:10 and the third in bits 9:0. This applies to the background registers, the pixel inputs and `out_pix`.
- R9: When channel 1 wins, `out_alpha` is `ch1_alpha` if control bit 10 is set, and control bits 31:24 otherwise. For any other outcome `out_alpha` is 255.
- R10: After reset the control register holds 255 in bits 31:24 and zero elsewhere, and every corner and background register is zero. The outputs reset to `out_sel`=0, `out_pix`=0 and `out_alpha`=255.
- R11: Control bits 14:12 select the output component order, written as (bits 29:20, 19:10, 9:0) in terms of the input components A, B, C. The codes are 0:(A,B,C), 1:(B,C,A), 2:(C,A,B), 3:(A,C,B), 4:(B,A,C) and 5:(C,B,A). Codes 6 and 7 behave as code 0.
- R12: The write index selects the register. Index 0 is control. Indices 1, 2 and 3 are the first corners of channels 1, 2 and 3. Indices 4, 5 and 6 are their second corners. Indices 7, 8 and 9 are their background colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index for the write |
| cfg_wdata | input | 32 | Register write data |
| pos_x | input | 13 | Current raster X position |
| pos_y | input | 13 | Current raster Y position |
| ch1_pix | input | 30 | Channel 1 pixel colour |
| ch2_pix | input | 30 | Channel 2 pixel colour |
| ch3_pix | input | 30 | Channel 3 pixel colour |
| ch_vld | input | 3 | Per-channel pixel valid, bit 0 for channel 1 |
| ch1_alpha | input | 8 | Per-pixel alpha for channel 1 |
| out_sel | output | 2 | Winning channel, 0 for none |
| out_pix | output | 30 | Selected colour after component swap |
| out_alpha | output | 8 | Alpha of the selected layer |

## Verification
A configuration write and a pixel decision can land in the same clock: the write updates the register at the edge, while the decision registered at that same edge must still use the old setting. The bench provokes this by presenting a position inside channel 1's window in the very cycle that a write turns channel 1 off. It expects the old winner on the outputs first, then presents the same position again and expects the lower channel. Overlapping windows are the other concurrent case: several hits arrive in one cycle, and full raster sweeps check that the fixed priority resolves them.

// File: rtl/ovl_win_pkg.sv
package ovl_win_pkg;
  localparam int NCH       = 3;
  localparam int CW        = 13;
  localparam int COMP_W    = 10;
  localparam int AW        = 8;
  localparam int PIX_W     = 3 * COMP_W;
  localparam int IDX_W     = 4;
  localparam int DW        = 32;
  localparam int SEL_W     = 2;
  localparam int Y_LSB     = 16;
  localparam int ASEL_BIT  = 10;
  localparam int SWAP_LSB  = 12;
  localparam int ALPHA_LSB = 24;
  localparam logic [AW-1:0] ALPHA_OPAQUE = '1;

  typedef struct packed {
    logic [CW-1:0] y;
    logic [CW-1:0] x;
  } point_t;

  function automatic point_t unpack_pt(input logic [DW-1:0] w);
    point_t p;
    p.x = w[CW-1:0];
    p.y = w[Y_LSB+CW-1:Y_LSB];
    return p;
  endfunction

  // inclusive rectangle test; an all-zero corner pair disables the window
  function automatic logic covers(input point_t c1, input point_t c2, input point_t p);
    logic live;
    live = (c1 != '0) || (c2 != '0);
    return live && (p.x >= c1.x) && (p.x <= c2.x) && (p.y >= c1.y) && (p.y <= c2.y);
  endfunction

  function automatic logic [PIX_W-1:0] swap_comp(input logic [PIX_W-1:0] v, input logic [2:0] code);
    logic [COMP_W-1:0] a, b, c;
    a = v[3*COMP_W-1:2*COMP_W];
    b = v[2*COMP_W-1:COMP_W];
    c = v[COMP_W-1:0];
    case (code)
      3'd1:    return {b, c, a};
      3'd2:    return {c, a, b};
      3'd3:    return {a, c, b};
      3'd4:    return {b, a, c};
      3'd5:    return {c, b, a};
      default: return {a, b, c};
    endcase
  endfunction

  // channel index 0 is the top layer; its enable sits in the highest of the three bits
  function automatic int en_bit(input int ch);
    return NCH - 1 - ch;
  endfunction
endpackage

// File: rtl/ovl_win_regs.sv
module ovl_win_regs
  import ovl_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctl,
  output point_t           c1 [NCH],
  output point_t           c2 [NCH],
  output logic [PIX_W-1:0] bg [NCH]
);
  localparam logic [DW-1:0] CTL_RST = DW'(ALPHA_OPAQUE) << ALPHA_LSB;

  always_ff @(posedge clk) begin
    if (!rst_n)                         ctl <= CTL_RST;
    else if (we && idx == IDX_W'(0))    ctl <= wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [IDX_W-1:0] I_C1 = IDX_W'(1 + g);
    localparam logic [IDX_W-1:0] I_C2 = IDX_W'(1 + NCH + g);
    localparam logic [IDX_W-1:0] I_BG = IDX_W'(1 + 2 * NCH + g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c1[g] <= '0;
        c2[g] <= '0;
        bg[g] <= '0;
      end else if (we) begin
        if (idx == I_C1) c1[g] <= unpack_pt(wdata);
        if (idx == I_C2) c2[g] <= unpack_pt(wdata);
        if (idx == I_BG) bg[g] <= wdata[PIX_W-1:0];
      end
    end
  end

  assert_ctl_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctl[ALPHA_LSB +: AW] == ALPHA_OPAQUE);
endmodule

// File: rtl/ovl_win_hit.sv
module ovl_win_hit
  import ovl_win_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  ctl,
  input  point_t         c1 [NCH],
  input  point_t         c2 [NCH],
  input  point_t         pos,
  output logic [NCH-1:0] hit,
  output logic [NCH-1:0] win_off
);
  for (genvar g = 0; g < NCH; g++) begin : g_win
    logic in_rect;
    assign win_off[g] = (c1[g] == '0) && (c2[g] == '0);
    assign in_rect    = covers(c1[g], c2[g], pos);
    assign hit[g]     = in_rect && ctl[en_bit(g)];

    // R3: a zeroed window never produces a hit
    assert_zero_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_off[g] |-> !hit[g]);
    // R4: a cleared enable blocks the hit
    assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[en_bit(g)] |-> !hit[g]);
  end
endmodule

// File: rtl/ovl_win_mux.sv
module ovl_win_mux
  import ovl_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    ctl,
  input  logic [NCH-1:0]   hit,
  input  logic [PIX_W-1:0] pix [NCH],
  input  logic [PIX_W-1:0] bg [NCH],
  input  logic [NCH-1:0]   vld,
  input  logic [AW-1:0]    ch1_alpha,
  output logic [SEL_W-1:0] out_sel,
  output logic [PIX_W-1:0] out_pix,
  output logic [AW-1:0]    out_alpha
);
  logic [NCH-1:0]   winner_oh;
  logic [SEL_W-1:0] sel_d;
  logic [PIX_W-1:0] raw_d;
  logic [AW-1:0]    alpha_d;
  logic [AW-1:0]    top_alpha;
  logic             found;

  assign top_alpha = ctl[ASEL_BIT] ? ch1_alpha : ctl[ALPHA_LSB +: AW];

  always_comb begin
    winner_oh = '0;
    found     = 1'b0;
    sel_d     = '0;
    raw_d     = bg[0];
    alpha_d   = ALPHA_OPAQUE;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i] && !found) begin
        found        = 1'b1;
        winner_oh[i] = 1'b1;
        sel_d        = SEL_W'(i + 1);
        raw_d        = vld[i] ? pix[i] : bg[i];
        alpha_d      = (i == 0) ? top_alpha : ALPHA_OPAQUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sel   <= '0;
      out_pix   <= '0;
      out_alpha <= ALPHA_OPAQUE;
    end else begin
      out_sel   <= sel_d;
      out_pix   <= swap_comp(raw_d, ctl[SWAP_LSB +: 3]);
      out_alpha <= alpha_d;
    end
  end

  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner_oh));
  assert_top_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> out_sel == SEL_W'(1));
  assert_none_sel0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> out_sel == '0);
  assert_lower_opaque_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel != SEL_W'(1)) |-> out_alpha == ALPHA_OPAQUE);
  assert_default_alpha_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !ctl[ASEL_BIT]) |=> out_alpha == $past(ctl[ALPHA_LSB +: AW]));
endmodule

// File: rtl/ovl_win_select.sv
module ovl_win_select
  import ovl_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [CW-1:0]    pos_x,
  input  logic [CW-1:0]    pos_y,
  input  logic [PIX_W-1:0] ch1_pix,
  input  logic [PIX_W-1:0] ch2_pix,
  input  logic [PIX_W-1:0] ch3_pix,
  input  logic [NCH-1:0]   ch_vld,
  input  logic [AW-1:0]    ch1_alpha,
  output logic [SEL_W-1:0] out_sel,
  output logic [PIX_W-1:0] out_pix,
  output logic [AW-1:0]    out_alpha
);
  logic [DW-1:0]    ctl;
  point_t           c1 [NCH];
  point_t           c2 [NCH];
  logic [PIX_W-1:0] bg [NCH];
  logic [PIX_W-1:0] pix [NCH];
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   win_off;
  point_t           pos;

  assign pos.x  = pos_x;
  assign pos.y  = pos_y;
  assign pix[0] = ch1_pix;
  assign pix[1] = ch2_pix;
  assign pix[2] = ch3_pix;

  ovl_win_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .ctl(ctl), .c1(c1), .c2(c2), .bg(bg)
  );

  ovl_win_hit u_hit (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .c1(c1), .c2(c2), .pos(pos),
    .hit(hit), .win_off(win_off)
  );

  ovl_win_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .hit(hit), .pix(pix), .bg(bg),
    .vld(ch_vld), .ch1_alpha(ch1_alpha),
    .out_sel(out_sel), .out_pix(out_pix), .out_alpha(out_alpha)
  );

  // R1: a position covered by no window, with no hit, yields sel 0 one clock later
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_off == '1) |=> out_sel == '0);
endmodule

// File: tb/sim_ovl_win_select.sv
module sim_ovl_win_select;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16;
  localparam int FH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [12:0] pos_x = '0, pos_y = '0;
  logic [29:0] ch1_pix, ch2_pix, ch3_pix;
  logic [2:0]  ch_vld = 3'b111;
  logic [7:0]  ch1_alpha;
  logic [1:0]  out_sel;
  logic [29:0] out_pix;
  logic [7:0]  out_alpha;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // shadow configuration kept by the bench
  logic [31:0] m_ctl;
  logic [31:0] m_c1 [3];
  logic [31:0] m_c2 [3];
  logic [31:0] m_bg [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_win_select u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .pos_x(pos_x), .pos_y(pos_y), .ch1_pix(ch1_pix), .ch2_pix(ch2_pix), .ch3_pix(ch3_pix),
    .ch_vld(ch_vld), .ch1_alpha(ch1_alpha),
    .out_sel(out_sel), .out_pix(out_pix), .out_alpha(out_alpha)
  );

  function automatic logic [29:0] gen_pix(int ch, int x, int y);
    logic [9:0] a, b, c;
    a = 10'(ch * 100 + x);
    b = 10'(500 + y + ch);
    c = 10'(x * y + 3 * ch);
    return {a, b, c};
  endfunction

  assign ch1_pix   = gen_pix(1, int'(pos_x), int'(pos_y));
  assign ch2_pix   = gen_pix(2, int'(pos_x), int'(pos_y));
  assign ch3_pix   = gen_pix(3, int'(pos_x), int'(pos_y));
  assign ch1_alpha = 8'(pos_x * 13 + pos_y * 7);

  function automatic logic [31:0] pt(int x, int y);
    return (32'(y) << 16) | 32'(x);
  endfunction

  // reorder by listing which source component lands in each output slot
  function automatic logic [29:0] reorder(logic [29:0] v, int code);
    logic [9:0] s [3];
    int m [3];
    s[0] = v[29:20]; s[1] = v[19:10]; s[2] = v[9:0];
    case (code)
      1: m = '{1, 2, 0};
      2: m = '{2, 0, 1};
      3: m = '{0, 2, 1};
      4: m = '{1, 0, 2};
      5: m = '{2, 1, 0};
      default: m = '{0, 1, 2};
    endcase
    return {s[m[0]], s[m[1]], s[m[2]]};
  endfunction

  task automatic expect_at(int x, int y, output logic [1:0] es, output logic [29:0] ep,
                           output logic [7:0] ea);
    int win;
    logic [29:0] raw;
    win = -1;
    for (int ch = 2; ch >= 0; ch--) begin
      int x1, y1, x2, y2;
      x1 = int'(m_c1[ch][12:0]); y1 = int'(m_c1[ch][28:16]);
      x2 = int'(m_c2[ch][12:0]); y2 = int'(m_c2[ch][28:16]);
      if (m_ctl[2 - ch] && !(m_c1[ch] == 0 && m_c2[ch] == 0) &&
          x >= x1 && x <= x2 && y >= y1 && y <= y2)
        win = ch;
    end
    if (win < 0) begin
      es = 0; raw = m_bg[0][29:0]; ea = 8'd255;
    end else begin
      es = 2'(win + 1);
      raw = ch_vld[win] ? gen_pix(win + 1, x, y) : m_bg[win][29:0];
      if (win == 0) ea = m_ctl[10] ? 8'(x * 13 + y * 7) : m_ctl[31:24];
      else ea = 8'd255;
    end
    ep = reorder(raw, int'(m_ctl[14:12]));
  endtask

  task automatic compare(string req, logic [1:0] es, logic [29:0] ep, logic [7:0] ea);
    checks++;
    if (out_sel !== es || out_pix !== ep || out_alpha !== ea) begin
      errors++;
      $display("FAIL %s: sel=%0d pix=%h alpha=%0d expected sel=%0d pix=%h alpha=%0d",
               req, out_sel, out_pix, out_alpha, es, ep, ea);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 0) m_ctl = d;
    else if (idx <= 3) m_c1[idx - 1] = d;
    else if (idx <= 6) m_c2[idx - 4] = d;
    else if (idx <= 9) m_bg[idx - 7] = d;
  endtask

  task automatic probe(int x, int y, string req);
    logic [1:0] es; logic [29:0] ep; logic [7:0] ea;
    pos_x = 13'(x); pos_y = 13'(y);
    expect_at(x, y, es, ep, ea);
    @(posedge clk); @(negedge clk);
    compare(req, es, ep, ea);
  endtask

  task automatic sweep(string req);
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++)
        probe(x, y, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ctl = 32'hFF00_0000;
    for (int i = 0; i < 3; i++) begin m_c1[i] = 0; m_c2[i] = 0; m_bg[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: output reset values
    compare("R10 reset outputs", 2'd0, 30'd0, 8'd255);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: default alpha 255 reaches the output once channel 1 wins with bit 10 clear
    wr(1, pt(3, 3)); wr(4, pt(3, 3)); wr(0, 32'hFF00_0004);
    m_ctl = 32'hFF00_0004;
    probe(3, 3, "R10 reset alpha field");
    // R3: corner at origin with nonzero opposite corner still live
    wr(3, pt(0, 0)); wr(6, pt(12, 10));
    wr(1, pt(2, 2)); wr(4, pt(6, 5));
    wr(2, pt(4, 3)); wr(5, pt(10, 8));
    // R12 R8: backgrounds per index
    wr(7, {2'b00, 10'd1, 10'd2, 10'd3});
    wr(8, {2'b00, 10'd4, 10'd5, 10'd6});
    wr(9, {2'b00, 10'd7, 10'd8, 10'd9});
    wr(0, 32'h8000_0007);
    sweep("R2 R5 R6 R12 overlapping windows");
    // R4 R7 R9 R11: channel 1 off, per-pixel alpha, reverse order, channel 2 invalid
    ch_vld = 3'b101;
    wr(0, 32'h3300_5403);
    sweep("R4 R7 R11 ch1 disabled");
    ch_vld = 3'b111;
    // R3: zero both corners of channel 2
    wr(2, 0); wr(5, 0);
    wr(0, 32'h4400_0407);
    sweep("R3 R9 zeroed window");
    // R7: channel 1 invalid shows its own background
    ch_vld = 3'b110;
    probe(2, 2, "R7 ch1 invalid");
    probe(6, 5, "R7 ch1 invalid corner");
    ch_vld = 3'b111;
    // R11: each swap code
    for (int code = 1; code < 8; code++) begin
      wr(0, 32'h5000_0007 | (32'(code) << 12));
      probe(4, 4, "R11 swap inside ch1");
      probe(11, 9, "R11 swap inside ch3");
      probe(14, 11, "R11 swap background");
    end
    // R4: all channels off
    wr(0, 32'hFF00_0000);
    sweep("R4 R6 all disabled");
    // R1: write and decision in the same cycle
    begin
      logic [1:0] es; logic [29:0] ep; logic [7:0] ea;
      m_ctl = 32'h2000_0007;
      wr(0, 32'h2000_0007);
      pos_x = 13'd3; pos_y = 13'd3;
      expect_at(3, 3, es, ep, ea);
      cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = 32'h2000_0003;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      compare("R1 same-cycle write uses old config", es, ep, ea);
      m_ctl = 32'h2000_0003;
      probe(3, 3, "R1 next cycle uses new config");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule